// File: doc/BRIEF.md
# Randomized Substitution-Slot Scheduler

This block decides, slot by slot, which state byte a round's substitution unit works on. The sixteen byte substitutions of one round do not depend on one another, so the block issues them in a fresh random order on every round. When asked, it also mixes a fixed number of dummy slots into the round at random positions. A dummy slot points at a random byte, and its result is meant to be thrown away.

A single start strobe launches a round. The block then presents one slot per cycle, with a valid flag, a real/dummy flag and a byte index. One cycle after the last slot it raises a done pulse. The length of the round depends only on whether dummies were enabled when the round started, never on where the dummies fall. Shuffling costs no cycles, because the permutation is built one step ahead of each real slot rather than in a separate pass.

An internal 16-bit LFSR supplies all the randomness. A seed port makes any run repeatable for test.

Top module: `sbox_sched`

## Requirements
- R1: After reset, slot_valid, slot_real and done are low, the internal order register holds the identity order (entry i holds i), and the LFSR holds 16'hACE1.
- R2: The LFSR advances on every clock. The new bit0 is s[15]^s[13]^s[12]^s[10] and the other bits shift up by one place. While seed_load is high, the next state is seed_val instead, or 16'hACE1 if seed_val is zero.
- R3: A start seen while idle makes slots valid from the next cycle for exactly 16+D consecutive cycles if dummy_en was high at that clock, and for exactly 16 cycles otherwise (D defaults to 4).
- R4: Within one round, each byte index 0 to 15 appears on exactly one real slot.
- R5: Let k be the number of real slots already issued in the round and r be LFSR bits [3:0]. A real slot outputs order entry j = k + (r mod (16-k)) and then swaps entries k and j.
- R6: A slot is a dummy when dummy slots remain in the round and either all 16 real slots are done or LFSR bit 15 is 1. A dummy slot outputs LFSR bits [7:4] as its index and leaves the order register unchanged.
- R7: A round holds exactly D dummy slots when dummies are enabled and none when they are disabled.
- R8: done is high for exactly the one cycle after the last slot of a round.
- R9: A start that arrives while a round is in progress has no effect on that round.
- R10: The order register is not reset between rounds, so two rounds in a row produce different real orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a round when idle |
| dummy_en | input | 1 | Enables dummy slots, sampled with start |
| seed_load | input | 1 | Loads seed_val into the LFSR |
| seed_val | input | 16 | LFSR seed value |
| slot_valid | output | 1 | A slot is being issued this cycle |
| slot_real | output | 1 | The current slot is a real substitution |
| slot_idx | output | 4 | Byte index of the current slot |
| done | output | 1 | One-cycle pulse after the final slot |

## Verification
Rounds are run with dummies both disabled and enabled, under a loaded seed, a zero seed and the reset seed. A cycle-accurate model compares every slot against the design, which shows whether the selection and dummy decisions follow the LFSR exactly and not merely plausibly. Separate counts on the outputs alone confirm that each index appears once and that the round length is fixed, independent of the model. A start pulse in the middle of a round, a restart in the same cycle as done, and two consecutive rounds under one seed separate correct handling of repeated strobes and a persistent order from designs that restart, stretch the round or fall back to a fixed order.

// File: rtl/sbox_sched_pkg.sv
package sbox_sched_pkg;
  localparam int          RW        = 16;
  localparam logic [15:0] RND_RESET = 16'hACE1;

  function automatic logic [RW-1:0] rnd_advance(input logic [RW-1:0] s);
    return {s[RW-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/rng_lfsr16.sv
module rng_lfsr16
  import sbox_sched_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_load,
  input  logic [RW-1:0] seed_val,
  output logic [RW-1:0] rnd
);
  logic [RW-1:0] rnd_q, rnd_n;

  always_comb begin
    if (seed_load) rnd_n = (seed_val == '0) ? RND_RESET : seed_val;
    else           rnd_n = rnd_advance(rnd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= RND_RESET;
    else        rnd_q <= rnd_n;
  end

  assign rnd = rnd_q;

  // R2
  seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_val != '0) |=> rnd_q == $past(seed_val));
  // R2
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q != '0);
endmodule

// File: rtl/order_store.sv
module order_store #(
  parameter int NB = 16,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_en,
  input  logic [IW-1:0] pos_a,
  input  logic [IW-1:0] pos_b,
  output logic [IW-1:0] pick
);
  logic [NB-1:0][IW-1:0] ord_q, ord_n;

  always_comb begin
    ord_n = ord_q;
    if (swap_en) begin
      ord_n[pos_a] = ord_q[pos_b];
      ord_n[pos_b] = ord_q[pos_a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) ord_q[i] <= IW'(i);
    end else if (swap_en) begin
      ord_q <= ord_n;
    end
  end

  assign pick = ord_q[pos_b];

  logic [NB-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < NB; i++) present[ord_q[i]] = 1'b1;
  end

  // R4
  perm_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present == {NB{1'b1}});
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl #(
  parameter int NB = 16,
  parameter int ND = 4,
  localparam int KW = $clog2(NB + 1),
  localparam int DW = $clog2(ND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dummy_en,
  input  logic          coin,
  output logic          busy,
  output logic          dummy_slot,
  output logic          real_slot,
  output logic [KW-1:0] real_cnt,
  output logic          done
);
  logic          busy_q, busy_n;
  logic [KW-1:0] k_q, k_n;
  logic [DW-1:0] dl_q, dl_n;
  logic          done_q, done_n;
  logic          last;

  always_comb begin
    dummy_slot = busy_q && (dl_q != '0) && ((k_q == KW'(NB)) || coin);
    real_slot  = busy_q && !dummy_slot;
    last = (dummy_slot && dl_q == DW'(1) && k_q == KW'(NB)) ||
           (real_slot && k_q == KW'(NB - 1) && dl_q == '0);
    busy_n = busy_q;
    k_n    = k_q;
    dl_n   = dl_q;
    done_n = last;
    if (!busy_q && start) begin
      busy_n = 1'b1;
      k_n    = '0;
      dl_n   = dummy_en ? DW'(ND) : '0;
    end else if (busy_q) begin
      if (dummy_slot) dl_n = dl_q - DW'(1);
      if (real_slot)  k_n  = k_q + KW'(1);
      if (last)       busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      dl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      k_q    <= k_n;
      dl_q   <= dl_n;
      done_q <= done_n;
    end
  end

  assign busy     = busy_q;
  assign real_cnt = k_q;
  assign done     = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R4
  round_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (k_q == KW'(NB) && dl_q == '0));
  // R7
  dummy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_q <= DW'(ND));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && k_q >= $past(k_q)));
endmodule

// File: rtl/sbox_sched.sv
module sbox_sched
  import sbox_sched_pkg::*;
#(
  parameter int NB = 16,
  parameter int ND = 4,
  localparam int IW = $clog2(NB),
  localparam int KW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dummy_en,
  input  logic          seed_load,
  input  logic [RW-1:0] seed_val,
  output logic          slot_valid,
  output logic          slot_real,
  output logic [IW-1:0] slot_idx,
  output logic          done
);
  logic [RW-1:0] rnd;
  logic          busy, dummy_slot, real_slot;
  logic [KW-1:0] real_cnt;
  logic [KW-1:0] span, offs, sel_full;
  logic [IW-1:0] pick;

  rng_lfsr16 u_rng (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load),
    .seed_val(seed_val), .rnd(rnd)
  );

  slot_ctrl #(.NB(NB), .ND(ND)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .dummy_en(dummy_en),
    .coin(rnd[RW-1]), .busy(busy), .dummy_slot(dummy_slot),
    .real_slot(real_slot), .real_cnt(real_cnt), .done(done)
  );

  always_comb begin
    span     = (real_cnt >= KW'(NB)) ? KW'(1) : KW'(NB) - real_cnt;
    offs     = KW'(rnd[IW-1:0]) % span;
    sel_full = real_cnt + offs;
  end

  order_store #(.NB(NB)) u_ord (
    .clk(clk), .rst_n(rst_n), .swap_en(real_slot),
    .pos_a(real_cnt[IW-1:0]), .pos_b(sel_full[IW-1:0]), .pick(pick)
  );

  assign slot_valid = busy;
  assign slot_real  = real_slot;
  assign slot_idx   = dummy_slot ? rnd[2*IW-1:IW] : pick;

  // R5
  pick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    real_slot |-> (sel_full >= real_cnt && sel_full < KW'(NB)));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |-> !slot_real);
endmodule

// File: tb/sim_sbox_sched.sv
`timescale 1ns/1ps
module sim_sbox_sched;
  localparam int NB = 16;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dummy_en = 1'b0, seed_load = 1'b0;
  logic [15:0] seed_val = '0;
  logic slot_valid, slot_real, done;
  logic [3:0] slot_idx;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sbox_sched #(.NB(NB), .ND(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dummy_en(dummy_en),
    .seed_load(seed_load), .seed_val(seed_val), .slot_valid(slot_valid),
    .slot_real(slot_real), .slot_idx(slot_idx), .done(done)
  );

  // behavioural reference state
  logic [15:0] m_rnd;
  int m_ord[NB];
  bit m_busy, m_done;
  int m_k, m_dl;

  function automatic bit m_dummy();
    return m_busy && m_dl > 0 && (m_k == NB || m_rnd[15]);
  endfunction
  function automatic int m_sel();
    return m_k + (int'(m_rnd[3:0]) % (NB - m_k));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rnd = 16'hACE1;
      foreach (m_ord[i]) m_ord[i] = i;
      m_busy = 0; m_done = 0; m_k = 0; m_dl = 0;
    end else begin
      bit dm, lst;
      dm = m_dummy();
      m_done = 0;
      if (m_busy) begin
        if (dm) m_dl--;
        else begin
          int j, t;
          j = m_sel();
          t = m_ord[j]; m_ord[j] = m_ord[m_k]; m_ord[m_k] = t;
          m_k++;
        end
        lst = (m_k == NB && m_dl == 0);
        if (lst) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        m_busy = 1; m_k = 0; m_dl = dummy_en ? ND : 0;
      end
      if (seed_load) m_rnd = (seed_val == 0) ? 16'hACE1 : seed_val;
      else m_rnd = {m_rnd[14:0], m_rnd[15]^m_rnd[13]^m_rnd[12]^m_rnd[10]};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-round observation, from outputs only
  int seen[NB];
  int slots_seen, dummies_seen, exp_len;
  int order_now[$], order_prev[$];
  bit cmp_on = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit dm;
      dm = m_dummy();
      check(slot_valid == m_busy, "R3 slot_valid", slot_valid, m_busy);
      check(done == m_done, "R8 done", done, m_done);
      if (m_busy) begin
        check(slot_real == !dm, "R6 slot_real", slot_real, !dm);
        if (dm) check(slot_idx == m_rnd[7:4], "R6 dummy idx", slot_idx, m_rnd[7:4]);
        else    check(slot_idx == m_ord[m_sel()], "R5 R2 real idx", slot_idx, m_ord[m_sel()]);
      end
      if (slot_valid) begin
        slots_seen++;
        if (slot_real) begin seen[slot_idx]++; order_now.push_back(slot_idx); end
        else dummies_seen++;
      end
    end
  end

  task automatic clear_round();
    foreach (seen[i]) seen[i] = 0;
    slots_seen = 0; dummies_seen = 0;
    order_now.delete();
  endtask

  task automatic pulse_start(input bit den);
    @(negedge clk); start = 1; dummy_en = den;
    @(negedge clk); start = 0; dummy_en = 0;
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk); seed_load = 1; seed_val = s;
    @(negedge clk); seed_load = 0; seed_val = '0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    check(n < 200, "R8 done arrives", n, 0);
  endtask

  task automatic round_checks(input bit den);
    int once = 1;
    foreach (seen[i]) if (seen[i] != 1) once = 0;
    check(once == 1, "R4 each index once", once, 1);
    check(dummies_seen == (den ? ND : 0), "R7 dummy count", dummies_seen, den ? ND : 0);
    check(slots_seen == (den ? NB + ND : NB), "R3 round length", slots_seen, den ? NB + ND : NB);
  endtask

  task automatic run_round(input bit den);
    clear_round();
    pulse_start(den);
    wait_done();
    @(negedge clk);
    round_checks(den);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(slot_valid == 0, "R1 slot_valid", slot_valid, 0);
    check(slot_real == 0, "R1 slot_real", slot_real, 0);
    check(done == 0, "R1 done", done, 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1 identity order and reset seed, R5 selection
    run_round(0);
    order_prev = order_now;
    // R10 consecutive rounds differ
    run_round(0);
    check(order_prev != order_now, "R10 order changes", order_now.size(), order_prev.size());
    // R2 loaded seed, dummies enabled
    load_seed(16'h1234);
    run_round(1);
    // R2 zero seed falls back to reset value
    load_seed(16'h0000);
    run_round(1);
    // R9 start pulse mid-round
    clear_round();
    pulse_start(1);
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done();
    @(negedge clk);
    round_checks(1);
    // back-to-back: restart in the done cycle
    load_seed(16'hBEEF);
    clear_round();
    pulse_start(0);
    wait_done();
    start = 1; dummy_en = 1;
    @(negedge clk);
    start = 0; dummy_en = 0;
    round_checks(0);
    clear_round();
    wait_done();
    @(negedge clk);
    round_checks(1);
    repeat (4) @(negedge clk);
    check(slot_valid == 0, "R3 idle after round", slot_valid, 0);
    finish_up();
  end
endmodule